// File: doc/BRIEF.md
# Lockable Down-Counting Watchdog

This block is a watchdog timer for a system that has to recover by itself when its software stops responding. Software reaches it through a small register window with single-cycle read and write strobes, a byte offset and 32-bit data. Software chooses two periods from a table of sixteen powers of two: one for the first interval after the watchdog is switched on, and one for every interval after that. It then switches the watchdog on. From that point the watchdog cannot be switched off. Software must write a fixed key value to the restart register regularly. Each correct write reloads the down counter. Any other value is ignored.

If the counter reaches zero while the watchdog is on, the block raises a system reset request for a fixed number of cycles. It also reloads the counter, so the watchdog keeps guarding after the reset pulse. Software can read the live count at any time. The exponent base of the period table is a parameter, which lets a bench work with short periods.

Top module: `wdt_guard`

## Requirements
- R1: After reset, the enable bit, both period selects and the live count all read 0, and `sysRstReq` is low.
- R2: Writing 1 to bit 0 of the control register (offset 0x00) sets the enable bit. Once set, no write clears it; only `rstN` clears it. Reading offset 0x00 returns the enable bit in bit 0.
- R3: The period register at offset 0x04 holds the running-period select in bits [3:0] and the first-period select in bits [7:4]. A read returns these 8 bits, with bits [31:8] read as 0.
- R4: A select value i gives a period of 2^(BASE_EXP+i) cycles. The counter is loaded with this value and then counts down by one per cycle while enabled.
- R5: A write of exactly 0x00000076 to offset 0x0C loads the counter with the period chosen by the running-period select.
- R6: A write to offset 0x0C with any other value leaves the count unchanged.
- R7: While the watchdog is disabled, the count holds its value. Writes to the count register at offset 0x08 have no effect.
- R8: The write that changes the enable bit from 0 to 1 loads the counter with the period chosen by the first-period select. All later reloads use the running-period select.
- R9: When the count is 0 while the watchdog is enabled, on the next clock edge `sysRstReq` goes high for exactly PULSE_LEN cycles (default 8) and the counter reloads from the running-period select.
- R10: A read strobe returns the addressed register on `busRdata` on the following cycle. Reads of unmapped offsets return 0. When there is no read, `busRdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Single-cycle write strobe |
| busRd | input | 1 | Single-cycle read strobe |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after `busRd` |
| sysRstReq | output | 1 | System reset request pulse |

## Verification
The live count is readable, so a wrong load value or a missed decrement shows up in the very next count read. It appears as an offset from the value expected from the cycles elapsed since the last load. A wrong choice between the two period selects shows as a count that starts at the other power of two. A lost enable bit or a miscounted pulse length shows on `sysRstReq` at the expected expiry cycle. Checks sample one cycle after the edge on which each effect should land, so a one-cycle slip fails directly.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_RANGE = 'h04;
  localparam int OFF_COUNT = 'h08;
  localparam int OFF_KICK  = 'h0C;
  localparam logic [31:0] KICK_KEY = 32'h0000_0076;

  typedef struct packed {
    logic       load;   // reload counter this cycle
    logic       run;    // counting permitted
    logic [3:0] sel;    // period select for the load
  } cntStrobes_t;
endpackage

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int BASE_EXP = 16,
  parameter int CNT_W    = BASE_EXP + 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  wdt_pkg::cntStrobes_t     strobes,
  output logic [CNT_W-1:0]         curCount,
  output logic                     cntZero
);
  function automatic logic [CNT_W-1:0] periodOf(input logic [3:0] sel);
    return CNT_W'(1) << (BASE_EXP + int'(sel));
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN)                               curCount <= '0;
    else if (strobes.load)                   curCount <= periodOf(strobes.sel);
    else if (strobes.run && curCount != '0)  curCount <= curCount - CNT_W'(1);
  end

  assign cntZero = (curCount == '0);

  // R7: with neither load nor run, the count holds
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.run) |=> $stable(curCount));

  // R4: a running nonzero count steps down by one
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && strobes.run && curCount != '0) |=> (curCount == $past(curCount) - CNT_W'(1)));

  // R5: a load leaves a single set bit in the count
  a_r5_load_pow2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> ($countones(curCount) == 1));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 32,
  parameter int PULSE_LEN = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWr,
  input  logic                  busRd,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [31:0]           busWdata,
  input  logic [CNT_W-1:0]      curCount,
  input  logic                  cntZero,
  output wdt_pkg::cntStrobes_t  strobes,
  output logic [31:0]           busRdata,
  output logic                  sysRstReq
);
  import wdt_pkg::*;
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic          enable;
  logic [3:0]    runSel, firstSel;
  logic [PW-1:0] pulseCnt;
  logic          wrCtrl, wrRange, wrKick, enRise, kick, expire;
  logic [31:0]   rdMux;

  assign wrCtrl  = busWr && (busAddr == ADDR_W'(OFF_CTRL));
  assign wrRange = busWr && (busAddr == ADDR_W'(OFF_RANGE));
  assign wrKick  = busWr && (busAddr == ADDR_W'(OFF_KICK));
  assign enRise  = wrCtrl && busWdata[0] && !enable;
  assign kick    = wrKick && (busWdata == KICK_KEY);
  assign expire  = enable && cntZero && !kick;

  always_comb begin
    strobes.load = enRise || kick || expire;
    strobes.run  = enable;
    strobes.sel  = enRise ? firstSel : runSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable   <= 1'b0;
      runSel   <= '0;
      firstSel <= '0;
    end else begin
      if (enRise)  enable <= 1'b1;
      if (wrRange) begin
        runSel   <= busWdata[3:0];
        firstSel <= busWdata[7:4];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 pulseCnt <= '0;
    else if (expire)           pulseCnt <= PW'(PULSE_LEN);
    else if (pulseCnt != '0)   pulseCnt <= pulseCnt - PW'(1);
  end
  assign sysRstReq = (pulseCnt != '0);

  always_comb begin
    rdMux = '0;
    if (busAddr == ADDR_W'(OFF_CTRL))       rdMux = {31'b0, enable};
    else if (busAddr == ADDR_W'(OFF_RANGE)) rdMux = {24'b0, firstSel, runSel};
    else if (busAddr == ADDR_W'(OFF_COUNT)) rdMux = 32'(curCount);
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= busRd ? rdMux : '0;
  end

  // R2: the enable bit never falls while out of reset
  a_r2_enable_sticky: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> enable);

  // R9: expiry raises the reset request on the next cycle
  a_r9_pulse_start: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cntZero && !kick) |=> sysRstReq);

  // R6: a wrong key to the restart offset causes no reload
  a_r6_bad_key: assert property (@(posedge clk) disable iff (!rstN)
    (wrKick && busWdata != KICK_KEY && !(enable && cntZero)) |-> !strobes.load);

  // R10: with no read strobe the read bus returns to zero
  a_r10_rd_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> (busRdata == '0));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int ADDR_W    = 8,
  parameter int BASE_EXP  = 16,
  parameter int PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              sysRstReq
);
  localparam int CNT_W = BASE_EXP + 16;

  wdt_pkg::cntStrobes_t strobes;
  logic [CNT_W-1:0]     curCount;
  logic                 cntZero;

  wdt_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .curCount(curCount), .cntZero(cntZero),
    .strobes(strobes), .busRdata(busRdata), .sysRstReq(sysRstReq));

  wdt_count #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .curCount(curCount), .cntZero(cntZero));
endmodule

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;
  timeunit 1ns; timeprecision 100ps;
  localparam int BASE = 4;
  localparam int PULSE = 8;

  logic clk = 1'b0, rstN = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sysRstReq;

  int errs = 0, checks = 0, ticks = 0, loadTick = 0, curP = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  wdt_guard #(.ADDR_W(8), .BASE_EXP(BASE), .PULSE_LEN(PULSE)) u_wdt_guard (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sysRstReq(sysRstReq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1; ticks++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    step();
    busWr = 1'b0; busWdata = '0;
  endtask

  // driver: pushes the expected read data, then issues the strobe
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    busRd = 1'b1; busAddr = a;
    step();
    busRd = 1'b0;
  endtask

  function automatic logic [31:0] cntExp();
    return 32'(curP - (ticks - loadTick));
  endfunction

  // monitor: pops an expectation for each read it sees
  always begin
    @(posedge clk);
    if (busRd) begin
      #1;
      if (expQ.size() == 0) chk("R10 unexpected read", busRdata, 32'hx);
      else chk(tagQ.pop_front(), busRdata, expQ.pop_front());
    end
  end

  task automatic waitExpiry();
    while (ticks < loadTick + curP) step();
    chk("R9 no request before expiry", 32'(sysRstReq), 32'd0);
    step();
    loadTick = ticks;
  endtask

  initial begin
    #100000;
    errs++; checks++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rstN = 1'b1; ticks = 0;
    chk("R1 reset request low", 32'(sysRstReq), 32'd0);
    rd(8'h00, 32'd0, "R1 enable after reset");
    rd(8'h08, 32'd0, "R1 count after reset");
    rd(8'h04, 32'd0, "R1 range after reset");

    wr(8'h04, 32'hFFFF_FF01);            // run sel 1 (32), first sel 0 (16)
    rd(8'h04, 32'h01, "R3 range fields");
    wr(8'h08, 32'd123);
    idle(3);
    rd(8'h08, 32'd0, "R7 count held and not writable");
    chk("R7 no request while disabled", 32'(sysRstReq), 32'd0);
    rd(8'h14, 32'd0, "R10 unmapped read");
    idle(1);
    chk("R10 idle read bus", busRdata, 32'd0);

    wr(8'h00, 32'd1); loadTick = ticks; curP = 16;
    rd(8'h00, 32'd1, "R2 enable set");
    rd(8'h08, cntExp(), "R8 first period loaded");
    wr(8'h00, 32'd0);
    rd(8'h00, 32'd1, "R2 enable sticky");
    wr(8'h0C, 32'h75);
    rd(8'h08, cntExp(), "R6 wrong key ignored");
    wr(8'h0C, 32'h176);
    rd(8'h08, cntExp(), "R6 near key ignored");

    wr(8'h0C, 32'h76); loadTick = ticks; curP = 32;
    rd(8'h08, cntExp(), "R5 key reloads running period");

    waitExpiry();
    chk("R9 request rises", 32'(sysRstReq), 32'd1);
    for (int i = 1; i < PULSE; i++) begin
      step();
      chk("R9 request held", 32'(sysRstReq), 32'd1);
    end
    step();
    chk("R9 request falls after pulse", 32'(sysRstReq), 32'd0);
    rd(8'h08, cntExp(), "R9 reload from running period");

    wr(8'h04, 32'h03);
    wr(8'h0C, 32'h76); loadTick = ticks; curP = 128;
    rd(8'h08, cntExp(), "R4 period two to the seven");
    idle(5);
    rd(8'h08, cntExp(), "R4 counts down");

    rstN = 1'b0; idle(2); rstN = 1'b1; idle(1);
    chk("R1 request cleared by reset", 32'(sysRstReq), 32'd0);
    rd(8'h00, 32'd0, "R2 reset clears enable");
    wr(8'h04, 32'h21);                   // first sel 2 (64), run sel 1 (32)
    wr(8'h00, 32'd1); loadTick = ticks; curP = 64;
    rd(8'h08, cntExp(), "R8 first period differs from running");
    waitExpiry(); curP = 32;
    chk("R9 second run request", 32'(sysRstReq), 32'd1);
    rd(8'h08, cntExp(), "R8 later reload uses running period");
    idle(2);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule